// File: doc/BRIEF.md
# SPI NOR flash command sequencer

This block is the byte-level command engine of a serial NOR flash slave. A bit shifter upstream delivers each received byte as a one-cycle strobe. It also signals each new chip-select assertion. For every strobe the engine decides what the byte means: a new opcode, an address, dummy or mode byte, program data, or a filler byte during a read. It then registers the byte to shift out on the next transfer.

The engine keeps the current array address, the write-enable latch and a short response buffer for status and identification reads. Reads go through a combinational memory port: the engine presents an address and samples the data in the same cycle. Programming hands one byte per transfer to a separate array engine, and so does erasing. The number of bytes collected after an opcode depends on the opcode. For the dual-I/O and quad-I/O reads it also depends on the manufacturer byte of the configured identification code.

Top module: `spi_nor_cmd_seq`

## Requirements
- R1: In the idle state every strobed byte is decoded as an opcode. The byte returned for an opcode transfer, and for every collected address, dummy or mode byte, is 0x00. Opcode 0x00 does nothing. Any byte outside the supported set (00, 01, 02, 03, 04, 05, 06, 0B, 20, 32, 3B, 52, 6B, 9F, A2, BB, C7, D8, EB) raises err_pulse for one cycle and leaves the engine idle.
- R2: Read 0x03, the three program opcodes 0x02, 0xA2 and 0x32, and the erases 0x20, 0x52 and 0xD8 collect 3 bytes. The fast read 0x0B and the dual-output and quad-output reads 0x3B and 0x6B collect 4 bytes.
- R3: When the manufacturer byte (bits 23:16 of the identification code) is 0xEF or 0x01, the dual-I/O read 0xBB collects 4 bytes and the quad-I/O read 0xEB collects 6. For any other manufacturer byte the counts are 5 and 8.
- R4: The address is taken from the first three collected bytes, most significant byte first, reduced modulo DEV_BYTES.
- R5: In the read state each transfer returns the memory byte at the current address. The address then increments, wrapping from DEV_BYTES-1 to 0.
- R6: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 returns one byte with the latch in bit 1 and all other bits zero.
- R7: Opcode 0x9F returns the three identification bytes, most significant first. It then returns the two extended bytes, high byte first, when the extended code is nonzero. After the last byte the engine is idle.
- R8: In the program state each received byte leads to a one-cycle prog_valid carrying the current address and that byte. The address then increments and wraps like a read.
- R9: Completing the address of 0x20, 0x52 or 0xD8 issues a one-cycle erase_valid at the address, with erase_kind 0, 1 or 2 respectively, and returns to idle.
- R10: Chip erase 0xC7 issues erase_valid with erase_kind 3 and address 0 only while the latch is set. Otherwise it raises err_pulse and issues no erase.
- R11: Write status 0x01 collects one byte only while the latch is set, and clears the latch when that byte arrives. With the latch clear, the next byte is decoded as an opcode.
- R12: cs_start forces the idle state and clears the byte counters, abandoning any collection, read, program or response in progress.
- R13: tx_byte, err_pulse and the request outputs are registered. They change on the clock edge that accepts the strobe and hold until the next strobe. After reset all of them are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_start | input | 1 | Pulse marking a new chip-select assertion |
| rx_valid | input | 1 | Strobe: one received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Registered byte for the next shift-out |
| mem_addr | output | ADDR_W | Memory read address (current address) |
| mem_rd_en | output | 1 | Memory read taken this cycle |
| mem_rd_data | input | 8 | Memory read data, combinational from mem_addr |
| prog_valid | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | 8 | Program data byte |
| erase_valid | output | 1 | One-cycle erase request |
| erase_addr | output | ADDR_W | Erase address |
| erase_kind | output | 2 | 0: 4 KiB, 1: 32 KiB, 2: sector, 3: whole chip |
| err_pulse | output | 1 | One-cycle error: unknown opcode or chip erase while protected |

## Verification
Two instances run side by side. One has manufacturer byte 0xEF and no extended code; the other has manufacturer 0x20 and a nonzero extended code. This shows whether the dual-I/O and quad-I/O byte counts and the ID length follow the configuration rather than a fixed value. Every one of the 256 opcode values is swept, which separates supported opcodes from unknown ones and a protected chip erase from an enabled one. Reads start at several addresses, including two bytes before the top of the array, with junk in the address bits above the array size. A wrong byte count, a wrong byte order or a missing wrap therefore shows up as wrong data. Write status and a chip select dropped mid-collection are each driven with a follow-up byte that reads back differently depending on whether it was collected or decoded.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;

   localparam logic [7:0] OPC_NOP        = 8'h00;
   localparam logic [7:0] OPC_SR_WRITE   = 8'h01;
   localparam logic [7:0] OPC_PROG       = 8'h02;
   localparam logic [7:0] OPC_READ       = 8'h03;
   localparam logic [7:0] OPC_WEL_CLR    = 8'h04;
   localparam logic [7:0] OPC_SR_READ    = 8'h05;
   localparam logic [7:0] OPC_WEL_SET    = 8'h06;
   localparam logic [7:0] OPC_READ_FAST  = 8'h0B;
   localparam logic [7:0] OPC_ERASE_4K   = 8'h20;
   localparam logic [7:0] OPC_PROG_X4    = 8'h32;
   localparam logic [7:0] OPC_READ_DO    = 8'h3B;
   localparam logic [7:0] OPC_ERASE_32K  = 8'h52;
   localparam logic [7:0] OPC_READ_QO    = 8'h6B;
   localparam logic [7:0] OPC_ID_READ    = 8'h9F;
   localparam logic [7:0] OPC_PROG_X2    = 8'hA2;
   localparam logic [7:0] OPC_READ_DIO   = 8'hBB;
   localparam logic [7:0] OPC_ERASE_CHIP = 8'hC7;
   localparam logic [7:0] OPC_ERASE_BLK  = 8'hD8;
   localparam logic [7:0] OPC_READ_QIO   = 8'hEB;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROG,
      ST_READ,
      ST_COLLECT,
      ST_RESP
   } seq_state_t;

   typedef enum logic [1:0] {
      ERK_4K    = 2'd0,
      ERK_32K   = 2'd1,
      ERK_BLOCK = 2'd2,
      ERK_CHIP  = 2'd3
   } erase_kind_t;

   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_PROG,
      ACT_READ,
      ACT_ERASE,
      ACT_SR_WRITE
   } post_act_t;

   typedef struct packed {
      logic        known;
      logic        collect;
      logic [3:0]  need;
      post_act_t   act;
      erase_kind_t ekind;
      logic        wel_set;
      logic        wel_clr;
      logic        rsp_status;
      logic        rsp_id;
      logic        chip_erase;
   } op_info_t;

   // Bytes gathered after a dual-I/O (quad=0) or quad-I/O (quad=1) read opcode.
   function automatic logic [3:0] io_read_need(input logic [7:0] mfr, input logic quad);
      logic short_form;
      short_form = (mfr == 8'hEF) || (mfr == 8'h01);
      if (quad) return short_form ? 4'd6 : 4'd8;
      return short_form ? 4'd4 : 4'd5;
   endfunction

endpackage

// File: rtl/spi_nor_op_decode.sv
module spi_nor_op_decode
   import spi_nor_pkg::*;
#(
   parameter logic [7:0] MFR_ID = 8'hEF
) (
   input  logic [7:0] opcode,
   output op_info_t   info
);

   localparam logic [3:0] NEED_DIO = io_read_need(MFR_ID, 1'b0);
   localparam logic [3:0] NEED_QIO = io_read_need(MFR_ID, 1'b1);

   always_comb begin
      info       = '0;
      info.known = 1'b1;
      info.act   = ACT_NONE;
      info.ekind = ERK_4K;
      case (opcode)
         OPC_NOP: ;
         OPC_SR_WRITE: begin
            info.collect = 1'b1;
            info.need    = 4'd1;
            info.act     = ACT_SR_WRITE;
         end
         OPC_WEL_CLR:    info.wel_clr    = 1'b1;
         OPC_WEL_SET:    info.wel_set    = 1'b1;
         OPC_SR_READ:    info.rsp_status = 1'b1;
         OPC_ID_READ:    info.rsp_id     = 1'b1;
         OPC_ERASE_CHIP: info.chip_erase = 1'b1;
         OPC_PROG, OPC_PROG_X2, OPC_PROG_X4: begin
            info.collect = 1'b1;
            info.need    = 4'd3;
            info.act     = ACT_PROG;
         end
         OPC_READ: begin
            info.collect = 1'b1;
            info.need    = 4'd3;
            info.act     = ACT_READ;
         end
         OPC_READ_FAST, OPC_READ_DO, OPC_READ_QO: begin
            info.collect = 1'b1;
            info.need    = 4'd4;
            info.act     = ACT_READ;
         end
         OPC_READ_DIO: begin
            info.collect = 1'b1;
            info.need    = NEED_DIO;
            info.act     = ACT_READ;
         end
         OPC_READ_QIO: begin
            info.collect = 1'b1;
            info.need    = NEED_QIO;
            info.act     = ACT_READ;
         end
         OPC_ERASE_4K: begin
            info.collect = 1'b1;
            info.need    = 4'd3;
            info.act     = ACT_ERASE;
            info.ekind   = ERK_4K;
         end
         OPC_ERASE_32K: begin
            info.collect = 1'b1;
            info.need    = 4'd3;
            info.act     = ACT_ERASE;
            info.ekind   = ERK_32K;
         end
         OPC_ERASE_BLK: begin
            info.collect = 1'b1;
            info.need    = 4'd3;
            info.act     = ACT_ERASE;
            info.ekind   = ERK_BLOCK;
         end
         default: info.known = 1'b0;
      endcase
   end

endmodule

// File: rtl/spi_nor_resp_buf.sv
module spi_nor_resp_buf #(
   parameter logic [23:0] ID_CODE  = 24'hEF4017,
   parameter logic [15:0] EXT_CODE = 16'h0000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_status,
   input  logic       load_id,
   input  logic       wel_in,
   input  logic       pop,
   output logic [7:0] rsp_byte,
   output logic       rsp_last
);

   localparam int ID_LEN = (EXT_CODE != 16'h0000) ? 5 : 3;

   logic [7:0] id_tab [5];
   logic [2:0] idx_q;
   logic       is_stat_q;
   logic       snap_q;

   assign id_tab[0] = ID_CODE[23:16];
   assign id_tab[1] = ID_CODE[15:8];
   assign id_tab[2] = ID_CODE[7:0];

   generate
      if (ID_LEN == 5) begin : g_ext_id
         assign id_tab[3] = EXT_CODE[15:8];
         assign id_tab[4] = EXT_CODE[7:0];
      end else begin : g_base_id
         assign id_tab[3] = 8'h00;
         assign id_tab[4] = 8'h00;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q     <= '0;
         is_stat_q <= 1'b0;
         snap_q    <= 1'b0;
      end else if (load_status) begin
         idx_q     <= '0;
         is_stat_q <= 1'b1;
         snap_q    <= wel_in;
      end else if (load_id) begin
         idx_q     <= '0;
         is_stat_q <= 1'b0;
      end else if (pop) begin
         idx_q     <= idx_q + 3'd1;
      end
   end

   always_comb begin
      if (is_stat_q) begin
         rsp_byte = {6'b0, snap_q, 1'b0};
         rsp_last = 1'b1;
      end else begin
         rsp_byte = (idx_q < 3'd5) ? id_tab[idx_q] : 8'h00;
         rsp_last = (idx_q == 3'(ID_LEN - 1));
      end
   end

endmodule

// File: rtl/spi_nor_addr_unit.sv
module spi_nor_addr_unit #(
   parameter int ADDR_W    = 24,
   parameter int DEV_BYTES = 1 << 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_cnt,
   input  logic              cap_valid,
   input  logic [7:0]        cap_byte,
   input  logic              load,
   input  logic              step,
   output logic [3:0]        cnt,
   output logic [ADDR_W-1:0] asm_addr,
   output logic [ADDR_W-1:0] cur_addr
);

   localparam logic [ADDR_W-1:0] AMASK = ADDR_W'(DEV_BYTES - 1);

   logic [7:0]  buf_q [3];
   logic [7:0]  merged [3];
   logic [23:0] asm24;

   // The byte arriving this cycle overrides its buffer slot so that the
   // address is complete on the strobe of the last collected byte.
   generate
      for (genvar j = 0; j < 3; j++) begin : g_merge
         assign merged[j] = (cap_valid && cnt == 4'(j)) ? cap_byte : buf_q[j];
      end
   endgenerate

   assign asm24    = {merged[0], merged[1], merged[2]};
   assign asm_addr = ADDR_W'(asm24) & AMASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int k = 0; k < 3; k++) buf_q[k] <= 8'h00;
      end else if (clr_cnt) begin
         cnt <= '0;
      end else if (cap_valid) begin
         cnt <= cnt + 4'd1;
         if (cnt < 4'd3) buf_q[cnt[1:0]] <= cap_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cur_addr <= '0;
      else if (load)  cur_addr <= asm_addr;
      else if (step)  cur_addr <= (cur_addr + 1'b1) & AMASK;
   end

endmodule

// File: rtl/spi_nor_cmd_seq.sv
module spi_nor_cmd_seq
   import spi_nor_pkg::*;
#(
   parameter int          ADDR_W    = 24,
   parameter int          DEV_BYTES = 1 << 20,
   parameter logic [23:0] ID_CODE   = 24'hEF4017,
   parameter logic [15:0] EXT_CODE  = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_start,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   output logic [7:0]        tx_byte,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd_en,
   input  logic [7:0]        mem_rd_data,
   output logic              prog_valid,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [7:0]        prog_data,
   output logic              erase_valid,
   output logic [ADDR_W-1:0] erase_addr,
   output logic [1:0]        erase_kind,
   output logic              err_pulse
);

   localparam logic [7:0] MFR_ID = ID_CODE[23:16];

   generate
      if ((DEV_BYTES & (DEV_BYTES - 1)) != 0 || DEV_BYTES < 2) begin : g_bad_size
         $error("DEV_BYTES must be a power of two");
      end
      if (longint'(DEV_BYTES) > (64'd1 << ADDR_W)) begin : g_bad_width
         $error("ADDR_W too narrow for DEV_BYTES");
      end
   endgenerate

   seq_state_t  state_q;
   post_act_t   pend_act_q;
   erase_kind_t pend_kind_q;
   logic [3:0]  need_q;
   logic        wel_q;

   op_info_t          info;
   logic [3:0]        cnt;
   logic [ADDR_W-1:0] asm_addr;
   logic [ADDR_W-1:0] cur_addr;
   logic [7:0]        rsp_byte;
   logic              rsp_last;

   logic rx_take, in_idle, in_coll, in_read, in_prog, in_resp;
   logic go_collect, coll_last;

   assign rx_take    = rx_valid && !cs_start;
   assign in_idle    = (state_q == ST_IDLE);
   assign in_coll    = (state_q == ST_COLLECT);
   assign in_read    = (state_q == ST_READ);
   assign in_prog    = (state_q == ST_PROG);
   assign in_resp    = (state_q == ST_RESP);
   assign go_collect = info.collect && !(info.act == ACT_SR_WRITE && !wel_q);
   assign coll_last  = ((cnt + 4'd1) == need_q);

   assign mem_addr  = cur_addr;
   assign mem_rd_en = rx_take && in_read;

   spi_nor_op_decode #(.MFR_ID(MFR_ID)) u_dec (
      .opcode (rx_byte),
      .info   (info)
   );

   spi_nor_addr_unit #(.ADDR_W(ADDR_W), .DEV_BYTES(DEV_BYTES)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_cnt   (cs_start || (rx_take && in_idle)),
      .cap_valid (rx_take && in_coll),
      .cap_byte  (rx_byte),
      .load      (rx_take && in_coll && coll_last),
      .step      (rx_take && (in_read || in_prog)),
      .cnt       (cnt),
      .asm_addr  (asm_addr),
      .cur_addr  (cur_addr)
   );

   spi_nor_resp_buf #(.ID_CODE(ID_CODE), .EXT_CODE(EXT_CODE)) u_rsp (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_status (rx_take && in_idle && info.rsp_status),
      .load_id     (rx_take && in_idle && info.rsp_id),
      .wel_in      (wel_q),
      .pop         (rx_take && in_resp),
      .rsp_byte    (rsp_byte),
      .rsp_last    (rsp_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pend_act_q  <= ACT_NONE;
         pend_kind_q <= ERK_4K;
         need_q      <= '0;
         wel_q       <= 1'b0;
         tx_byte     <= 8'h00;
         prog_valid  <= 1'b0;
         prog_addr   <= '0;
         prog_data   <= 8'h00;
         erase_valid <= 1'b0;
         erase_addr  <= '0;
         erase_kind  <= 2'd0;
         err_pulse   <= 1'b0;
      end else begin
         prog_valid  <= 1'b0;
         erase_valid <= 1'b0;
         err_pulse   <= 1'b0;
         if (cs_start) begin
            state_q <= ST_IDLE;
         end else if (rx_valid) begin
            unique case (state_q)
               ST_IDLE: begin
                  tx_byte <= 8'h00;
                  if (!info.known) err_pulse <= 1'b1;
                  if (info.wel_set) wel_q <= 1'b1;
                  if (info.wel_clr) wel_q <= 1'b0;
                  if (go_collect) begin
                     state_q     <= ST_COLLECT;
                     need_q      <= info.need;
                     pend_act_q  <= info.act;
                     pend_kind_q <= info.ekind;
                  end
                  if (info.rsp_status || info.rsp_id) state_q <= ST_RESP;
                  if (info.chip_erase) begin
                     if (wel_q) begin
                        erase_valid <= 1'b1;
                        erase_addr  <= '0;
                        erase_kind  <= ERK_CHIP;
                     end else begin
                        err_pulse   <= 1'b1;
                     end
                  end
               end
               ST_COLLECT: begin
                  tx_byte <= 8'h00;
                  if (coll_last) begin
                     state_q <= ST_IDLE;
                     case (pend_act_q)
                        ACT_PROG: state_q <= ST_PROG;
                        ACT_READ: state_q <= ST_READ;
                        ACT_ERASE: begin
                           erase_valid <= 1'b1;
                           erase_addr  <= asm_addr;
                           erase_kind  <= pend_kind_q;
                        end
                        ACT_SR_WRITE: wel_q <= 1'b0;
                        default: ;
                     endcase
                  end
               end
               ST_READ: begin
                  tx_byte <= mem_rd_data;
               end
               ST_PROG: begin
                  tx_byte    <= 8'h00;
                  prog_valid <= 1'b1;
                  prog_addr  <= cur_addr;
                  prog_data  <= rx_byte;
               end
               ST_RESP: begin
                  tx_byte <= rsp_byte;
                  if (rsp_last) state_q <= ST_IDLE;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/spi_nor_cmd_seq_chk.sv
module spi_nor_cmd_seq_chk
   import spi_nor_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int DEV_BYTES = 1 << 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_start,
   input logic              rx_valid,
   input logic [7:0]        rx_byte,
   input seq_state_t        state_q,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              wel_q,
   input logic              prog_valid,
   input logic              erase_valid,
   input logic [1:0]        erase_kind,
   input logic              err_pulse
);

   localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEV_BYTES - 1);

   AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> ($past(rx_valid) && !$past(cs_start)));                 // R1

   AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !cs_start && state_q == ST_READ) |=>
      (cur_addr == (($past(cur_addr) == TOP_ADDR) ? '0 : ADDR_W'($past(cur_addr) + 1'b1)))); // R5

   AST_WEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !cs_start && state_q == ST_IDLE && rx_byte == 8'h06) |=> wel_q); // R6

   AST_PROG_FROM_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      prog_valid |-> ($past(state_q) == ST_PROG && $past(rx_valid)));       // R8

   AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      !(prog_valid && erase_valid));                                        // R9

   AST_CHIP_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_valid && erase_kind == 2'd3) |-> $past(wel_q));                // R10

   AST_CS_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_start |=> (state_q == ST_IDLE));                                   // R12

endmodule

bind spi_nor_cmd_seq spi_nor_cmd_seq_chk #(.ADDR_W(ADDR_W), .DEV_BYTES(DEV_BYTES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_start    (cs_start),
   .rx_valid    (rx_valid),
   .rx_byte     (rx_byte),
   .state_q     (state_q),
   .cur_addr    (cur_addr),
   .wel_q       (wel_q),
   .prog_valid  (prog_valid),
   .erase_valid (erase_valid),
   .erase_kind  (erase_kind),
   .err_pulse   (err_pulse)
);

// File: tb/tb_spi_nor_cmd_seq.sv
module tb_spi_nor_cmd_seq;

   localparam int DEV = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        cs_s [2];
   logic        rv_s [2];
   logic [7:0]  rb_s [2];
   logic [7:0]  tx_s [2];
   logic [23:0] ma_s [2];
   logic        mre_s [2];
   logic [7:0]  md_s [2];
   logic        pv_s [2];
   logic [23:0] pa_s [2];
   logic [7:0]  pd_s [2];
   logic        ev_s [2];
   logic [23:0] ea_s [2];
   logic [1:0]  ek_s [2];
   logic        er_s [2];

   int checks = 0;
   int fails  = 0;

   logic [7:0]  c_tx;
   logic        c_err, c_pv, c_ev;
   logic [23:0] c_pa, c_ea;
   logic [7:0]  c_pd;
   logic [1:0]  c_ek;

   function automatic logic [7:0] mdat(input logic [23:0] a);
      return 8'(a[7:0] * 5) ^ a[11:4] ^ 8'h3C;
   endfunction

   assign md_s[0] = mdat(ma_s[0]);
   assign md_s[1] = mdat(ma_s[1]);

   spi_nor_cmd_seq #(.ADDR_W(24), .DEV_BYTES(DEV), .ID_CODE(24'hEF4017), .EXT_CODE(16'h0000)) dut (
      .clk(clk), .rst_n(rst_n), .cs_start(cs_s[0]), .rx_valid(rv_s[0]), .rx_byte(rb_s[0]),
      .tx_byte(tx_s[0]), .mem_addr(ma_s[0]), .mem_rd_en(mre_s[0]), .mem_rd_data(md_s[0]),
      .prog_valid(pv_s[0]), .prog_addr(pa_s[0]), .prog_data(pd_s[0]),
      .erase_valid(ev_s[0]), .erase_addr(ea_s[0]), .erase_kind(ek_s[0]), .err_pulse(er_s[0]));

   spi_nor_cmd_seq #(.ADDR_W(24), .DEV_BYTES(DEV), .ID_CODE(24'h20BA18), .EXT_CODE(16'h4D01)) dut_alt (
      .clk(clk), .rst_n(rst_n), .cs_start(cs_s[1]), .rx_valid(rv_s[1]), .rx_byte(rb_s[1]),
      .tx_byte(tx_s[1]), .mem_addr(ma_s[1]), .mem_rd_en(mre_s[1]), .mem_rd_data(md_s[1]),
      .prog_valid(pv_s[1]), .prog_addr(pa_s[1]), .prog_data(pd_s[1]),
      .erase_valid(ev_s[1]), .erase_addr(ea_s[1]), .erase_kind(ek_s[1]), .err_pulse(er_s[1]));

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
      end
   endtask

   task automatic xfer(input int d, input logic [7:0] b);
      @(negedge clk);
      rv_s[d] = 1'b1;
      rb_s[d] = b;
      @(negedge clk);
      rv_s[d] = 1'b0;
      c_tx  = tx_s[d];
      c_err = er_s[d];
      c_pv  = pv_s[d];
      c_pa  = pa_s[d];
      c_pd  = pd_s[d];
      c_ev  = ev_s[d];
      c_ea  = ea_s[d];
      c_ek  = ek_s[d];
   endtask

   task automatic csel(input int d);
      @(negedge clk);
      cs_s[d] = 1'b1;
      @(negedge clk);
      cs_s[d] = 1'b0;
   endtask

   task automatic send_addr(input int d, input logic [23:0] a);
      for (int i = 0; i < 3; i++) begin
         xfer(d, a[23 - 8*i -: 8]);
         chk(c_tx == 8'h00, "R1 addr byte reply", c_tx, 0);
      end
   endtask

   // opcode, address, extra filler bytes, then n data bytes checked
   task automatic addr_read(input int d, input logic [7:0] op, input int start,
                            input int extra, input int n, input string rq);
      csel(d);
      xfer(d, op);
      send_addr(d, 24'(start) | 24'h5A5000);
      for (int i = 0; i < extra; i++) begin
         xfer(d, 8'hA5);
         chk(c_tx == 8'h00, rq, c_tx, 0);
      end
      for (int i = 0; i < n; i++) begin
         xfer(d, 8'hFF);
         chk(c_tx == mdat(24'((start + i) % DEV)), rq, c_tx, mdat(24'((start + i) % DEV)));
      end
   endtask

   task automatic status_is(input int d, input logic [7:0] exp, input string rq);
      xfer(d, 8'h05);
      xfer(d, 8'h00);
      chk(c_tx == exp, rq, c_tx, exp);
   endtask

   function automatic bit op_known(input logic [7:0] op);
      case (op)
         8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h0B, 8'h20, 8'h32,
         8'h3B, 8'h52, 8'h6B, 8'h9F, 8'hA2, 8'hBB, 8'hC7, 8'hD8, 8'hEB: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] id_a [3];
      logic [7:0] id_b [5];
      int starts [4];
      logic [7:0] er_ops [3];
      bit wel_m;
      id_a = '{8'hEF, 8'h40, 8'h17};
      id_b = '{8'h20, 8'hBA, 8'h18, 8'h4D, 8'h01};
      starts = '{0, 'h123, 'hFFD, 'h7FF};
      er_ops = '{8'h20, 8'h52, 8'hD8};
      for (int d = 0; d < 2; d++) begin
         cs_s[d] = 1'b0; rv_s[d] = 1'b0; rb_s[d] = 8'h00;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R13: reset state of registered outputs
      for (int d = 0; d < 2; d++) begin
         chk(tx_s[d] == 8'h00, "R13 reset tx", tx_s[d], 0);
         chk(!er_s[d] && !pv_s[d] && !ev_s[d], "R13 reset pulses", {er_s[d], pv_s[d], ev_s[d]}, 0);
      end

      // R6: latch through status reads
      xfer(0, 8'h05);
      chk(c_tx == 8'h00, "R1 opcode reply", c_tx, 0);
      xfer(0, 8'hFF);
      chk(c_tx == 8'h00, "R6 status after reset", c_tx, 0);
      xfer(0, 8'h06);
      status_is(0, 8'h02, "R6 status after set");
      repeat (3) @(negedge clk);
      chk(tx_s[0] == 8'h02, "R13 reply holds", tx_s[0], 2);
      xfer(0, 8'h04);
      status_is(0, 8'h00, "R6 status after clear");

      // R7: identification, short and extended
      csel(0);
      xfer(0, 8'h9F);
      for (int i = 0; i < 3; i++) begin
         xfer(0, 8'h00);
         chk(c_tx == id_a[i], "R7 id byte", c_tx, id_a[i]);
      end
      status_is(0, 8'h00, "R7 idle after id");
      csel(1);
      xfer(1, 8'h9F);
      for (int i = 0; i < 5; i++) begin
         xfer(1, 8'h00);
         chk(c_tx == id_b[i], "R7 ext id byte", c_tx, id_b[i]);
      end
      status_is(1, 8'h00, "R7 idle after ext id");

      // R4/R5: plain read at several starts including wrap
      for (int k = 0; k < 4; k++) addr_read(0, 8'h03, starts[k], 0, 6, "R5 read stream");

      // R2: four-byte reads
      addr_read(0, 8'h0B, 'h200, 1, 3, "R2 fast read");
      addr_read(0, 8'h3B, 'h345, 1, 3, "R2 dual out read");
      addr_read(0, 8'h6B, 'hABC, 1, 3, "R2 quad out read");

      // R3: I/O read counts follow the manufacturer byte
      addr_read(0, 8'hBB, 'h300, 1, 3, "R3 dual io short");
      addr_read(1, 8'hBB, 'h300, 2, 3, "R3 dual io long");
      addr_read(0, 8'hEB, 'h5F0, 3, 3, "R3 quad io short");
      addr_read(1, 8'hEB, 'h5F0, 5, 3, "R3 quad io long");

      // R8: page program with wrap
      csel(0);
      xfer(0, 8'h02);
      send_addr(0, 24'h000FFE);
      for (int i = 0; i < 3; i++) begin
         xfer(0, 8'(8'h90 + i));
         chk(c_pv == 1'b1, "R8 prog pulse", c_pv, 1);
         chk(c_pa == 24'((4094 + i) % DEV), "R8 prog addr", c_pa, (4094 + i) % DEV);
         chk(c_pd == 8'(8'h90 + i) && c_tx == 8'h00, "R8 prog data", c_pd, 8'h90 + i);
      end

      // R9: sized erases
      for (int k = 0; k < 3; k++) begin
         csel(0);
         xfer(0, er_ops[k]);
         xfer(0, 8'h12);
         xfer(0, 8'h34);
         chk(c_ev == 1'b0, "R9 no early erase", c_ev, 0);
         xfer(0, 8'h56);
         chk(c_ev == 1'b1, "R9 erase pulse", c_ev, 1);
         chk(c_ea == 24'h000456, "R9 erase addr", c_ea, 'h456);
         chk(c_ek == 2'(k), "R9 erase kind", c_ek, k);
         status_is(0, 8'h00, "R9 idle after erase");
      end

      // R10: chip erase protection
      csel(0);
      xfer(0, 8'h04);
      xfer(0, 8'hC7);
      chk(c_err == 1'b1 && c_ev == 1'b0, "R10 protected chip erase", {c_err, c_ev}, 2);
      xfer(0, 8'h06);
      xfer(0, 8'hC7);
      chk(c_ev == 1'b1 && c_err == 1'b0, "R10 chip erase pulse", {c_err, c_ev}, 1);
      chk(c_ek == 2'd3 && c_ea == 24'h0, "R10 chip erase kind/addr", c_ek, 3);

      // R11: write status gated by the latch
      xfer(0, 8'h04);
      xfer(0, 8'h01);
      xfer(0, 8'h06);
      status_is(0, 8'h02, "R11 ignored without latch");
      xfer(0, 8'h01);
      xfer(0, 8'h06);
      status_is(0, 8'h00, "R11 collected and latch cleared");

      // R12: chip select abandons a collection
      xfer(0, 8'h06);
      csel(0);
      xfer(0, 8'h03);
      xfer(0, 8'h00);
      xfer(0, 8'h01);
      csel(0);
      status_is(0, 8'h02, "R12 idle after chip select");

      // R1: sweep every opcode value
      csel(0);
      xfer(0, 8'h04);
      wel_m = 1'b0;
      for (int op = 0; op < 256; op++) begin
         bit exp_err;
         csel(0);
         xfer(0, 8'(op));
         exp_err = !op_known(8'(op)) || (op == 'hC7 && !wel_m);
         chk(c_err == exp_err, "R1 opcode sweep err", c_err, exp_err);
         chk(c_tx == 8'h00, "R1 opcode sweep reply", c_tx, 0);
         if (op == 'h06) wel_m = 1'b1;
         if (op == 'h04) wel_m = 1'b0;
      end
      csel(0);
      status_is(0, 8'h02, "R1 idle after sweep");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule